// File: doc/BRIEF.md
# Dual-Output Timer Waveform Generator

This block is one timer channel working as a waveform generator. A single up-counter, advanced by one of several selectable clock-enable sources, forms the period shared by two PWM outputs, A and B. The counter restarts from zero on the cycle after it equals the period register. Each output has its own duty compare register and its own table. The table maps each of four events to an action on that output's level: its own compare match, the period match, an external event and a software trigger. Each action is none, set, clear or toggle.

A simple write-only register port loads the mode word, the three compare values and a command word. The command word can start or stop counting and can issue a software trigger. The software trigger zeroes the counter and forces each output to the level its table chooses. A constant output level is obtained by arming only the software-trigger action. The input reset is asynchronous and active low. It is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `wavegen_chan`

## Requirements
- R1: After reset the counter reads 0, both outputs are low, and counting is stopped until an enable command is written.
- R2: While running, on each cycle in which the selected tick input is high the counter advances by one. On a tick where it equals the period value (address 3) it returns to 0 instead.
- R3: Mode bits [2:0] select tick input 0 to 4 as the count enable. Codes 5 to 7 select no source, so the counter never advances.
- R4: Action fields are 2 bits wide, coded 00 none, 01 set, 10 clear, 11 toggle. Output A's fields are mode bits [9:8] own compare, [11:10] period match, [13:12] external event and [15:14] software trigger. Output B's fields sit 8 bits higher, at [17:16], [19:18], [21:20] and [23:22].
- R5: Output A's compare event uses the value at address 1 and output B's uses the value at address 2. Both share the period value.
- R6: Writing address 4 is a command: bit 0 starts counting, bit 1 stops it, bit 2 is a software trigger. A software trigger sets the counter to 0 and applies the software-trigger actions at that same clock edge, whether or not counting was running, including when combined with a start.
- R7: After a stop command the counter and both outputs hold their values. Stop wins over start when both bits are written together. A later start resumes counting from the held value.
- R8: When events coincide on an output, only events whose action is not none compete. Software trigger beats external event, which beats period match, which beats own compare.
- R9: The external event input applies its actions on every cycle it is high, whether or not counting is running.
- R10: Compare and period-match actions occur only on cycles in which the counter advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NUM_SRC | Count-enable pulses, one per clock source |
| ext_evt | input | 1 | External event, active high for one or more cycles |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 mode, 1 compare A, 2 compare B, 3 period, 4 command |
| reg_wdata | input | DATA_W | Register write data |
| wave_a | output | 1 | Output A level |
| wave_b | output | 1 | Output B level |
| count | output | CNT_W | Current counter value |

## Verification
On any output, the period match and the own-compare match fall in the same cycle whenever the compare value equals the period value. A near-exhaustive sweep over a 4-bit counter provokes this for every period. It loads every compare value from 0 up to the period, with the two outputs using opposite actions. Each cycle the bench checks each output against a closed-form level computed from the expected count. A second collision, the software trigger or external event against a period match, is provoked in two ways: by holding the external event high across several wraps, and by raising it in the same cycle as a start-plus-trigger command. The bench then checks that the level follows the higher-priority event, and that an event whose action is none does not mask a lower one.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // One output's event table; packed msb-first to match the mode word slice.
  typedef struct packed {
    act_e sw;
    act_e ext;
    act_e rc;
    act_e cmp;
  } out_act_t;

  localparam int MODE_W     = 24;
  localparam int ACT_OFS    = 8;   // first output's table position in the mode word
  localparam int OUT_STRIDE = 8;   // distance between the two outputs' tables
  localparam int NUM_OUT    = 2;

  localparam int ADR_MODE = 0;
  localparam int ADR_CMPA = 1;
  localparam int ADR_CMPB = 2;
  localparam int ADR_PER  = 3;
  localparam int ADR_CMD  = 4;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_TRIG  = 2;

endpackage

// File: rtl/wg_regs.sv
module wg_regs
  import wavegen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  cmpa_q,
  output logic [CNT_W-1:0]  cmpb_q,
  output logic [CNT_W-1:0]  per_q,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_trig
);

  logic [MODE_W-1:0] mode_d;
  logic [CNT_W-1:0]  cmpa_d, cmpb_d, per_d;
  logic              wr_cmd;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    mode_d = mode_q;
    cmpa_d = cmpa_q;
    cmpb_d = cmpb_q;
    per_d  = per_q;
    if (we) begin
      if (addr == ADDR_W'(ADR_MODE)) mode_d = wdata[MODE_W-1:0];
      if (addr == ADDR_W'(ADR_CMPA)) cmpa_d = wdata[CNT_W-1:0];
      if (addr == ADDR_W'(ADR_CMPB)) cmpb_d = wdata[CNT_W-1:0];
      if (addr == ADDR_W'(ADR_PER))  per_d  = wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      per_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      per_q  <= per_d;
    end
  end

  // Command bits act as one-cycle strobes in the write cycle itself.
  assign wr_cmd    = we && (addr == ADDR_W'(ADR_CMD));
  assign cmd_start = wr_cmd && wdata[CMD_START];
  assign cmd_stop  = wr_cmd && wdata[CMD_STOP];
  assign cmd_trig  = wr_cmd && wdata[CMD_TRIG];

endmodule

// File: rtl/wg_counter.sv
module wg_counter #(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 5,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               cmd_start,
  input  logic               cmd_stop,
  input  logic               cmd_trig,
  input  logic [CNT_W-1:0]   per,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               run_q,
  output logic               step,
  output logic               per_hit
);

  logic             sel_tick;
  logic [CNT_W-1:0] cnt_d;
  logic             run_d;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (clk_sel == SEL_W'(i)) sel_tick = src_tick[i];
    end
  end

  assign step    = run_q && sel_tick;
  assign per_hit = step && (cnt_q == per);

  always_comb begin
    run_d = run_q;
    if (cmd_stop)       run_d = 1'b0;
    else if (cmd_start) run_d = 1'b1;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cmd_trig)     cnt_d = '0;
    else if (per_hit) cnt_d = '0;
    else if (step)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/wg_output.sv
module wg_output
  import wavegen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  out_act_t         acts,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] cnt,
  input  logic             step,
  input  logic             per_hit,
  input  logic             ext_evt,
  input  logic             trig,
  output logic             wave_q
);

  logic cmp_hit;
  act_e sel_act;
  logic wave_d;

  assign cmp_hit = step && (cnt == cmp_val);

  // Later assignments override earlier ones: lowest priority first.
  always_comb begin
    sel_act = ACT_NONE;
    if (cmp_hit && acts.cmp != ACT_NONE) sel_act = acts.cmp;
    if (per_hit && acts.rc  != ACT_NONE) sel_act = acts.rc;
    if (ext_evt && acts.ext != ACT_NONE) sel_act = acts.ext;
    if (trig    && acts.sw  != ACT_NONE) sel_act = acts.sw;
  end

  always_comb begin
    case (sel_act)
      ACT_SET: wave_d = 1'b1;
      ACT_CLR: wave_d = 1'b0;
      ACT_TGL: wave_d = ~wave_q;
      default: wave_d = wave_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

endmodule

// File: rtl/wavegen_chan.sv
module wavegen_chan
  import wavegen_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 5,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               ext_evt,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               wave_a,
  output logic               wave_b,
  output logic [CNT_W-1:0]   count
);

  localparam int SEL_W = $clog2(NUM_SRC);

  logic [1:0]              rst_sync;
  logic                    rst_sn;
  logic [MODE_W-1:0]       mode_q;
  logic [CNT_W-1:0]        cmpa_q, cmpb_q, per_q, cnt_q;
  logic                    cmd_start, cmd_stop, cmd_trig;
  logic                    run_q, step, per_hit;
  logic [NUM_OUT-1:0]      wave_q;
  logic [NUM_OUT-1:0][CNT_W-1:0] cmp_arr;
  out_act_t                acts [NUM_OUT];
  logic                    unused_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  wg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sn),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .mode_q   (mode_q),
    .cmpa_q   (cmpa_q),
    .cmpb_q   (cmpb_q),
    .per_q    (per_q),
    .cmd_start(cmd_start),
    .cmd_stop (cmd_stop),
    .cmd_trig (cmd_trig)
  );

  wg_counter #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sn),
    .src_tick (src_tick),
    .clk_sel  (mode_q[SEL_W-1:0]),
    .cmd_start(cmd_start),
    .cmd_stop (cmd_stop),
    .cmd_trig (cmd_trig),
    .per      (per_q),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .step     (step),
    .per_hit  (per_hit)
  );

  assign cmp_arr[0] = cmpa_q;
  assign cmp_arr[1] = cmpb_q;

  for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
    assign acts[gi] = out_act_t'(mode_q[ACT_OFS + OUT_STRIDE*gi +: OUT_STRIDE]);

    wg_output #(.CNT_W(CNT_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_sn),
      .acts   (acts[gi]),
      .cmp_val(cmp_arr[gi]),
      .cnt    (cnt_q),
      .step   (step),
      .per_hit(per_hit),
      .ext_evt(ext_evt),
      .trig   (cmd_trig),
      .wave_q (wave_q[gi])
    );
  end

  assign unused_mode = ^mode_q;

  assign wave_a = wave_q[0];
  assign wave_b = wave_q[1];
  assign count  = cnt_q;

endmodule

// File: rtl/wavegen_chan_chk.sv
module wavegen_chan_chk #(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              step,
  input logic              trig,
  input logic              ext_evt,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  per,
  input logic [MODE_W-1:0] mode,
  input logic              wave_a,
  input logic              wave_b
);

  // R7: a stopped counter holds unless a trigger zeroes it
  p_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !trig) |=> $stable(cnt));

  // R2: wrap to zero at the period value
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !trig && cnt == per) |=> (cnt == '0));

  // R2: advance by one below the period value
  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !trig && cnt != per) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R6: trigger zeroes the counter
  p_trig_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt == '0));

  // R10: with no event source active the outputs cannot move
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !trig && !ext_evt) |=> ($stable(wave_a) && $stable(wave_b)));

  // R8: a trigger whose output-A action is set wins over everything
  p_trig_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode[15:14] == 2'b01) |=> wave_a);

endmodule

bind wavegen_chan wavegen_chan_chk #(.CNT_W(CNT_W), .MODE_W(wavegen_pkg::MODE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sn),
  .run    (run_q),
  .step   (step),
  .trig   (cmd_trig),
  .ext_evt(ext_evt),
  .cnt    (cnt_q),
  .per    (per_q),
  .mode   (mode_q),
  .wave_a (wave_a),
  .wave_b (wave_b)
);

// File: tb/wavegen_chan_tb.sv
module wavegen_chan_tb;

  localparam int CW = 4;
  localparam int DW = 32;
  localparam int NS = 5;
  localparam int AW = 3;

  localparam int START = 1;
  localparam int STOP  = 2;
  localparam int TRIG  = 4;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] src_tick;
  logic          ext_evt;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic          wave_a, wave_b;
  logic [CW-1:0] count;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int tc    = 0;

  wavegen_chan #(.CNT_W(CW), .DATA_W(DW), .NUM_SRC(NS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ext_evt(ext_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .wave_a(wave_a), .wave_b(wave_b), .count(count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Source 0 ticks every cycle, source 1 every third cycle, others idle.
  always @(negedge clk) begin
    tc <= tc + 1;
    src_tick <= {3'b000, ((tc + 1) % 3 == 0), 1'b1};
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all-req actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input int actual, input int expect_v);
    n_chk++;
    if (actual != expect_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expect_v);
    end
  endtask

  task automatic wr(input int adr, input int data);
    reg_we    = 1'b1;
    reg_addr  = AW'(adr);
    reg_wdata = DW'(data);
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int tbl(input int sw, input int ext, input int rc, input int cmp);
    return (sw << 6) | (ext << 4) | (rc << 2) | cmp;
  endfunction

  function automatic int mk(input int sel, input int a, input int b);
    return (b << 16) | (a << 8) | sel;
  endfunction

  int held_cnt, held_a;

  initial begin
    rst_n = 1'b0; ext_evt = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    src_tick = '0;
    cyc_n(3);
    rst_n = 1'b1;
    cyc_n(3);

    // R1: reset state and no counting before start
    chk("R1 count", count, 0);
    chk("R1 wave_a", wave_a, 0);
    chk("R1 wave_b", wave_b, 0);
    cyc_n(5);
    chk("R1 idle count", count, 0);

    // R4/R6: constant level from trigger actions only (A set, B toggle)
    wr(3, 3);
    wr(0, mk(0, tbl(1,0,0,0), tbl(3,0,0,0)));
    wr(4, START | TRIG);
    chk("R6 start+trig count", count, 0);
    chk("R4 sw set a", wave_a, 1);
    chk("R4 sw toggle b", wave_b, 1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R4 const a", wave_a, 1);
      chk("R4 const b", wave_b, 1);
    end
    wr(4, TRIG);
    chk("R6 trig running count", count, 0);
    chk("R4 toggle back b", wave_b, 0);
    chk("R4 set holds a", wave_a, 1);

    // R4: toggle on period match, period 3
    wr(0, mk(0, tbl(2,0,3,0), 0));
    wr(4, START | TRIG);
    chk("R6 trig clears a", wave_a, 0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R2 count p3", count, k % 4);
      chk("R4 toggle a", wave_a, (k / 4) % 2);
    end

    // R7: stop holds counter and outputs
    wr(4, STOP);
    held_cnt = count;
    held_a   = wave_a;
    cyc_n(6);
    chk("R7 hold count", count, held_cnt);
    chk("R7 hold a", wave_a, held_a);
    wr(4, START | STOP);
    cyc_n(3);
    chk("R7 stop wins count", count, held_cnt);
    wr(4, START);
    chk("R7 resume no jump", count, held_cnt);
    @(negedge clk);
    chk("R7 resume count", count, (held_cnt == 3) ? 0 : held_cnt + 1);

    // R9/R8: external event and priorities
    wr(4, STOP);
    wr(3, 2);
    wr(0, mk(0, tbl(2,1,2,0), 0));
    wr(4, TRIG);
    chk("R6 trig while stopped count", count, 0);
    chk("R6 trig while stopped a", wave_a, 0);
    ext_evt = 1'b1;
    @(negedge clk);
    ext_evt = 1'b0;
    chk("R9 ext while stopped a", wave_a, 1);
    chk("R9 no count", count, 0);
    ext_evt = 1'b1;
    wr(4, START | TRIG);
    chk("R8 trig beats ext", wave_a, 0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R8 ext beats period", wave_a, 1);
    end
    wr(0, mk(0, tbl(2,0,2,0), 0));
    cyc_n(4);
    chk("R8 none does not mask", wave_a, 0);
    ext_evt = 1'b0;

    // R3: source 1 ticks every third cycle
    wr(0, mk(1, 0, 0));
    wr(3, 15);
    wr(4, START | TRIG);
    cyc_n(30);
    chk("R3 slow source count", count, 10);

    // R3/R10: invalid select never counts, compare never fires
    wr(1, 0);
    wr(0, mk(5, tbl(1,0,0,2), 0));
    wr(4, START | TRIG);
    chk("R6 sel5 a", wave_a, 1);
    cyc_n(10);
    chk("R3 sel5 no count", count, 0);
    chk("R10 no compare when idle", wave_a, 1);

    // R2/R5/R8 sweep: A set/clear-on-cmp/set-on-period, B inverse
    wr(0, mk(0, tbl(1,0,1,2), tbl(2,0,2,1)));
    for (int per = 0; per < 16; per++) begin
      for (int ca = 0; ca <= per; ca++) begin
        wr(3, per);
        wr(1, ca);
        wr(2, per - ca);
        wr(4, START | TRIG);
        chk("R6 sweep start count", count, 0);
        chk("R5 sweep start a", wave_a, 1);
        chk("R5 sweep start b", wave_b, 0);
        for (int k = 1; k <= 2 * (per + 1); k++) begin
          @(negedge clk);
          chk("R2 sweep count", count, k % (per + 1));
          chk("R5 sweep a", wave_a, ((k % (per + 1)) <= ca) ? 1 : 0);
          chk("R5 sweep b", wave_b, ((k % (per + 1)) > (per - ca)) ? 1 : 0);
        end
      end
    end

    finish_run();
  end

endmodule